// File: doc/BRIEF.md
# Paced Peripheral DMA Channel

A single DMA channel that moves blocks of data between a peripheral FIFO at a fixed address and a range of memory, one burst at a time. Software writes the source and target pointers, a byte count and a control word through a small register port. Setting the run bit starts the channel. The channel then repeats the same burst sequence until the count is used up:

- Read one burst from the source into an internal staging buffer.
- Write that buffer out to the target, reading the entries back in the same order.
- Advance the pointers and reduce the count.

A single request/grant bus carries every access. Each access has the width that the control word selects.

The control word also holds two flow flags. When either flag is set, every burst waits for the peripheral request line before it starts. When both flags are clear, bursts follow one another with no gap. Each burst moves the smaller of the programmed burst size and the remaining count, so the final burst may be short. When the count reaches zero, the channel drops its run bit, raises a sticky done bit and goes idle.

The state machine has five states:

| State | What it does | Leaves to |
|---|---|---|
| IDLE | Waits for the run bit | WAIT, if a flow flag is set; otherwise READ |
| WAIT | Waits for the peripheral request | READ, when the request is high |
| READ | Issues the source accesses | WRITE, when the last source access is granted |
| WRITE | Issues the target accesses | UPDATE, when the last target access is granted |
| UPDATE | Applies the pointer and count changes for one cycle | IDLE |

Top module: `pdma_chan`

## Requirements
- R1: After reset, all four registers read zero (source at index 0, target at 1, count at 2, control at 3) and `bus_req` is low.
- R2: Writing the control register with bit 0 set starts the channel (run=1, done=0) when the count is non-zero. When the count is zero, the same write sets done (bit 1) and leaves run clear, with no bus access.
- R3: The width code is control bits [3:2]. The code maps 01 to 1 byte, 10 to 2 bytes, and 11 or 00 to 4 bytes. `bus_size` shows the code. Within a burst, beat k uses the base address plus k times the width on a side whose increment bit is set (bit 6 for the source, bit 7 for the target). A side whose increment bit is clear keeps its base address on every beat.
- R4: The burst code is control bits [5:4]. The code maps 10 to 16 bytes, 11 to 32 bytes, and 01 or 00 to 8 bytes. With the 2-byte width, code 11 is limited to 16 bytes.
- R5: A burst moves step = min(count, burst size) bytes in ceil(step/width) beats. All source reads come first, then all target writes carry the read data in the same order.
- R6: After each burst, each pointer whose increment bit is set grows by step, and the count shrinks by step.
- R7: When the count reaches zero, run clears, done sets and stays set, and no further bus request is made.
- R8: If either flow flag is set (bit 8 for the source, bit 9 for the target), a burst begins only in a cycle where `dreq` is high, and once begun it completes whatever `dreq` does afterwards. With both flags clear, bursts run without `dreq`.
- R9: Register writes while run is set have no effect.
- R10: A pending bus request keeps its address, direction and write data unchanged until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq | input | 1 | Peripheral request for pacing |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Byte address of the access |
| bus_size | output | 2 | Width code of the access |
| bus_wdata | output | DW | Write data |
| bus_gnt | input | 1 | Access accepted this cycle |
| bus_rdata | input | DW | Read data, valid with grant |

## Verification
The bound checker watches these rules on every cycle:

- Bus requests stay stable while they wait for a grant.
- A wait for the request line cannot end while `dreq` is low.
- No read follows a write inside a burst.
- The count shrinks by exactly the burst step.
- No bus request is made while run is clear.
- Run and done are never set together.

Only the bench scenarios can show the rest:

- The exact address sequence on fixed and incrementing sides.
- That the data written matches what was read, in the same order.
- The beat counts for every width and burst code.
- The limit applied to the 2-byte width.
- The final pointer values.
- That writes made while the channel runs are ignored.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_READ,
        S_WRITE,
        S_UPDATE
    } pdma_state_e;

    localparam logic [1:0] REG_SRC  = 2'd0;
    localparam logic [1:0] REG_DST  = 2'd1;
    localparam logic [1:0] REG_LEN  = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    // control bits [9:2]
    typedef struct packed {
        logic       flow_tgt;
        logic       flow_src;
        logic       inc_dst;
        logic       inc_src;
        logic [1:0] burst_code;
        logic [1:0] width_code;
    } pdma_cfg_t;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        unique case (code)
            2'b01:   return 3'd1;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [5:0] burst_bytes(input logic [1:0] bcode,
                                               input logic [1:0] wcode);
        unique case (bcode)
            2'b10:   return 6'd16;
            2'b11:   return (wcode == 2'b10) ? 6'd16 : 6'd32;
            default: return 6'd8;
        endcase
    endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          upd,
    input  logic [LW-1:0] step,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [LW-1:0] len,
    output pdma_cfg_t     cfg,
    output logic          run,
    output logic          done
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src  <= '0;
            dst  <= '0;
            len  <= '0;
            cfg  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else if (upd) begin
            if (cfg.inc_src) src <= src + AW'(step);
            if (cfg.inc_dst) dst <= dst + AW'(step);
            len <= len - step;
            if (len == step) begin
                run  <= 1'b0;
                done <= 1'b1;
            end
        end else if (cfg_we && !run) begin
            unique case (cfg_addr)
                REG_SRC: src <= cfg_wdata[AW-1:0];
                REG_DST: dst <= cfg_wdata[AW-1:0];
                REG_LEN: len <= cfg_wdata[LW-1:0];
                REG_CTRL: begin
                    cfg <= cfg_wdata[9:2];
                    if (cfg_wdata[0]) begin
                        if (len == '0) begin
                            done <= 1'b1;
                        end else begin
                            run  <= 1'b1;
                            done <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (cfg_addr)
            REG_SRC:  cfg_rdata = 32'(src);
            REG_DST:  cfg_rdata = 32'(dst);
            REG_LEN:  cfg_rdata = 32'(len);
            REG_CTRL: cfg_rdata = {22'd0, cfg, done, run};
        endcase
    end

endmodule

// File: rtl/pdma_stage_buf.sv
module pdma_stage_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pdma_fsm.sv
module pdma_fsm
    import pdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int DEPTH = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  pdma_cfg_t     cfg,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [LW-1:0] len,
    input  logic          dreq,
    input  logic          bus_gnt,
    output pdma_state_e   state,
    output logic [LW-1:0] step,
    output logic          upd,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic          buf_we,
    output logic [IW-1:0] idx
);

    pdma_state_e   nxt;
    logic [2:0]    wb;
    logic [1:0]    shamt;
    logic [LW-1:0] burst_len;
    logic [LW-1:0] beats;
    logic          last;
    logic          paced;
    logic [AW-1:0] offset;

    always_comb begin
        wb        = width_bytes(cfg.width_code);
        shamt     = (wb == 3'd1) ? 2'd0 : (wb == 3'd2) ? 2'd1 : 2'd2;
        burst_len = LW'(burst_bytes(cfg.burst_code, cfg.width_code));
        step      = (len < burst_len) ? len : burst_len;
        beats     = (step + LW'(wb) - LW'(1)) >> shamt;
        last      = (LW'(idx) == beats - LW'(1));
        paced     = cfg.flow_src | cfg.flow_tgt;
        offset    = AW'(idx) << shamt;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // beat index inside a burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if ((state == S_READ || state == S_WRITE) && bus_gnt) begin
            idx <= last ? '0 : idx + IW'(1);
        end else if (state == S_IDLE) begin
            idx <= '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (run) nxt = paced ? S_WAIT : S_READ;
            S_WAIT:   if (dreq) nxt = S_READ;
            S_READ:   if (bus_gnt && last) nxt = S_WRITE;
            S_WRITE:  if (bus_gnt && last) nxt = S_UPDATE;
            S_UPDATE: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        bus_addr = '0;
        buf_we   = 1'b0;
        upd      = 1'b0;
        unique case (state)
            S_IDLE, S_WAIT: ;
            S_READ: begin
                bus_req  = 1'b1;
                bus_addr = src + (cfg.inc_src ? offset : '0);
                buf_we   = bus_gnt;
            end
            S_WRITE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = dst + (cfg.inc_dst ? offset : '0);
            end
            S_UPDATE: upd = 1'b1;
        endcase
    end

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int LW        = 16,
    parameter int MAX_BURST = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          dreq,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_gnt,
    input  logic [DW-1:0] bus_rdata
);

    localparam int DEPTH = MAX_BURST;
    localparam int IW    = $clog2(DEPTH);

    pdma_state_e   state;
    pdma_cfg_t     cfg;
    logic [AW-1:0] src, dst;
    logic [LW-1:0] len, step;
    logic          run, done, upd, buf_we;
    logic [IW-1:0] idx;
    logic [DW-1:0] buf_rd;

    pdma_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .upd(upd), .step(step),
        .src(src), .dst(dst), .len(len), .cfg(cfg), .run(run), .done(done)
    );

    pdma_fsm #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg(cfg), .src(src), .dst(dst),
        .len(len), .dreq(dreq), .bus_gnt(bus_gnt), .state(state), .step(step),
        .upd(upd), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .buf_we(buf_we), .idx(idx)
    );

    pdma_stage_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
        .clk(clk), .we(buf_we), .waddr(idx), .wdata(bus_rdata),
        .raddr(idx), .rdata(buf_rd)
    );

    assign bus_size  = cfg.width_code;
    assign bus_wdata = bus_we ? buf_rd : '0;

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk
    import pdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dreq,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_gnt,
    input pdma_state_e   state,
    input logic          run,
    input logic          done,
    input logic [LW-1:0] len,
    input logic [LW-1:0] step
);

    a_r10_hold_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_wdata));

    a_r8_wait_for_dreq: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_WAIT && !dreq |=> state == S_WAIT);

    a_r6_len_shrinks_by_step: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_UPDATE |=> len == $past(len) - $past(step));

    a_r5_no_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we |=> bus_we || !bus_req);

    a_r7_no_bus_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !bus_req);

    a_r7_done_excludes_run: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !done);

    a_r5_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> step != '0);

endmodule

bind pdma_chan pdma_chan_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .state(state), .run(run), .done(done), .len(len), .step(step)
);

// File: tb/pdma_chan_tb.sv
module pdma_chan_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dreq = 1'b0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_gnt = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #(CLK_P/2) clk = ~clk;

    pdma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
        .bus_rdata(bus_rdata)
    );

    int tests = 0;
    int fails = 0;

    logic        lg_we   [0:255];
    logic [31:0] lg_addr [0:255];
    logic [31:0] lg_data [0:255];
    logic [1:0]  lg_size [0:255];
    int          lg_n = 0;
    int          rd_cnt = 0;
    bit          stall_en = 1'b0;
    bit          stall_tog = 1'b0;

    logic        ex_we   [0:255];
    logic [31:0] ex_addr [0:255];
    logic [31:0] ex_data [0:255];
    int          ex_n;

    // bus responder and access log
    always @(negedge clk) begin
        if (bus_req && (!stall_en || stall_tog)) begin
            bus_gnt = 1'b1;
            if (!bus_we) begin
                bus_rdata = 32'hA500_0000 + 32'(rd_cnt);
                rd_cnt++;
            end
            if (lg_n < 256) begin
                lg_we[lg_n]   = bus_we;
                lg_addr[lg_n] = bus_addr;
                lg_data[lg_n] = bus_we ? bus_wdata : bus_rdata;
                lg_size[lg_n] = bus_size;
            end
            lg_n++;
        end else begin
            bus_gnt = 1'b0;
        end
        stall_tog = ~stall_tog;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int wbytes(input logic [1:0] c);
        if (c == 2'b01) return 1;
        if (c == 2'b10) return 2;
        return 4;
    endfunction

    function automatic int bbytes(input logic [1:0] b, input logic [1:0] w);
        if (b == 2'b10) return 16;
        if (b == 2'b11) return (w == 2'b10) ? 16 : 32;
        return 8;
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic clear_log();
        @(posedge clk);
        lg_n = 0;
        rd_cnt = 0;
    endtask

    task automatic build_exp(input logic [1:0] w, b, input bit incs, incd,
                             input int len, input logic [31:0] s0, d0);
        int rem = len;
        int r = 0;
        int wbt = wbytes(w);
        logic [31:0] s = s0;
        logic [31:0] d = d0;
        ex_n = 0;
        while (rem > 0) begin
            int st = (rem < bbytes(b, w)) ? rem : bbytes(b, w);
            int bt = (st + wbt - 1) / wbt;
            for (int k = 0; k < bt; k++) begin
                ex_we[ex_n] = 1'b0;
                ex_addr[ex_n] = s + (incs ? 32'(k * wbt) : 32'd0);
                ex_data[ex_n] = 32'hA500_0000 + 32'(r + k);
                ex_n++;
            end
            for (int k = 0; k < bt; k++) begin
                ex_we[ex_n] = 1'b1;
                ex_addr[ex_n] = d + (incd ? 32'(k * wbt) : 32'd0);
                ex_data[ex_n] = 32'hA500_0000 + 32'(r + k);
                ex_n++;
            end
            r += bt;
            if (incs) s += 32'(st);
            if (incd) d += 32'(st);
            rem -= st;
        end
    endtask

    task automatic run_case(input logic [1:0] w, b, input bit incs, incd,
                            input int len, input bit stall, input bit poke,
                            input bit paced);
        logic [31:0] s0, d0, d;
        int waited;
        int first_tx;
        s0 = 32'h4010_0000 + 32'(w) * 32'h10;
        d0 = 32'h8000_0000 + 32'(len) * 32'h40 + 32'(b) * 32'h4000;
        stall_en = stall;
        cfg_write(2'd0, s0);
        cfg_write(2'd1, d0);
        cfg_write(2'd2, 32'(len));
        build_exp(w, b, incs, incd, len, s0, d0);
        clear_log();
        cfg_write(2'd3, {22'd0, 1'b0, paced, incd, incs, b, w, 1'b0, 1'b1});
        cfg_read(2'd3, d);
        chk(d[1:0] == 2'b01, "R2 start sets run and clears done", d[1:0], 2'b01);
        if (poke) begin
            cfg_write(2'd0, 32'hDEAD_BEEF);
            cfg_write(2'd2, 32'd3);
            cfg_write(2'd3, 32'd0);
        end
        if (paced) begin
            repeat (15) @(negedge clk);
            chk(lg_n == 0, "R8 no access before request", lg_n, 0);
            dreq = 1'b1;
            @(negedge clk);
            dreq = 1'b0;
            repeat (60) @(negedge clk);
            first_tx = 2 * (((len < bbytes(b, w) ? len : bbytes(b, w)) + wbytes(w) - 1) / wbytes(w));
            chk(lg_n == first_tx, "R8 one burst per request, completes with dreq low",
                lg_n, first_tx);
            dreq = 1'b1;
        end
        waited = 0;
        do begin
            cfg_read(2'd3, d);
            waited++;
        end while (d[0] && waited < 3000);
        dreq = 1'b0;
        chk(d[1:0] == 2'b10, "R7 run clears and done sets at end (R8 no dreq needed when unpaced)",
            d[1:0], 2'b10);
        chk(lg_n == ex_n, "R4,R5 access count", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            chk(lg_we[i] == ex_we[i] && lg_addr[i] == ex_addr[i] && lg_size[i] == w,
                "R3 direction, address and size of beat", lg_addr[i], ex_addr[i]);
            chk(lg_data[i] == ex_data[i], "R5 staged data order", lg_data[i], ex_data[i]);
        end
        cfg_read(2'd0, d);
        chk(d == s0 + (incs ? 32'(len) : 32'd0), poke ? "R9 source write ignored" : "R6 final source",
            d, s0 + (incs ? 32'(len) : 32'd0));
        cfg_read(2'd1, d);
        chk(d == d0 + (incd ? 32'(len) : 32'd0), "R6 final target", d, d0 + (incd ? 32'(len) : 32'd0));
        cfg_read(2'd2, d);
        chk(d == 32'd0, "R6 count drained", d, 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        int case_no;
        int lens [3];
        lens[0] = 5; lens[1] = 24; lens[2] = 37;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            cfg_read(2'(a), d);
            chk(d == 32'd0, "R1 register reset value", d, 32'd0);
        end
        chk(bus_req == 1'b0, "R1 no bus request after reset", bus_req, 1'b0);

        // R2 zero length completes at once
        clear_log();
        cfg_write(2'd3, 32'h0000_0001);
        cfg_read(2'd3, d);
        chk(d[1:0] == 2'b10, "R2 zero count sets done without running", d[1:0], 2'b10);
        repeat (10) @(negedge clk);
        chk(lg_n == 0, "R2 zero count makes no access", lg_n, 0);
        cfg_read(2'd3, d);
        chk(d[1] == 1'b1, "R7 done is sticky", d[1], 1'b1);

        // sweep widths, burst codes, lengths, directions, stalls
        case_no = 0;
        for (int wi = 1; wi <= 3; wi++) begin
            for (int bi = 1; bi <= 3; bi++) begin
                for (int li = 0; li < 3; li++) begin
                    run_case(2'(wi), 2'(bi), case_no[0], !case_no[0], lens[li],
                             case_no[1], 1'b0, 1'b0);
                    case_no++;
                end
            end
        end
        // reserved codes behave as 4-byte width, 8-byte burst
        run_case(2'b00, 2'b00, 1'b0, 1'b1, 13, 1'b1, 1'b0, 1'b0);
        // R9 writes while running are ignored
        run_case(2'b01, 2'b01, 1'b1, 1'b1, 40, 1'b1, 1'b1, 1'b0);
        // R8 paced by the peripheral request
        run_case(2'b01, 2'b01, 1'b0, 1'b1, 20, 1'b0, 1'b0, 1'b1);
        run_case(2'b10, 2'b11, 1'b0, 1'b1, 37, 1'b1, 1'b0, 1'b1);

        cfg_read(2'd3, d);
        repeat (20) @(negedge clk);
        cfg_read(2'd3, d);
        chk(d[1:0] == 2'b10, "R7 done held while idle", d[1:0], 2'b10);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        fails++;
        tests++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule